// File: doc/BRIEF.md
# Serial Port with RTS/CTS Flow Control

This block is a byte-wide asynchronous serial port that sits on a simple host bus. The bus uses one-cycle read and write strobes. It reaches two registers: a status word and a data port. A byte written to the data port joins a transmit queue. The transmitter sends each queued byte as a frame made of one start bit, eight data bits sent least significant bit first, and two stop bits. Reading the data port removes the oldest byte from a 20-entry receive queue.

Baud timing comes from a free-running divider that produces an oversampling tick. There are sixteen ticks per bit. The receiver confirms a start bit halfway through it, samples each data bit at its centre, and keeps a byte only if that byte ends with a high stop bit.

Flow control works in both directions. Both handshake lines are active-low. `rts_n` is raised while the receive queue holds 16 or more bytes, which leaves four entries of slack for a sender that reacts late. If a byte completes while the receive queue is full, that byte is thrown away and reception continues. The transmitter starts no new frame while the synchronized `cts_n` is high, but it finishes any frame it has already begun. Both asynchronous inputs are resynchronized: the serial input passes through three flops and `cts_n` through two.

Top module: `serial_port_flow`

## Requirements
- R1: Every transmitted frame consists of one low start bit, then eight data bits with the least significant bit first, then two high stop bits. Each bit lasts 16*CLK_DIV clock cycles, and the line rests high between frames.
- R2: A write strobe to address 1 queues `bus_wdata[7:0]` for transmission, and queued bytes are sent in the order they were written. A write while the 4-entry transmit queue is full is discarded.
- R3: A read strobe to address 0 returns the status word. Bit 0 is 1 when the transmit queue is not full, bit 1 is 1 when the receive queue is not empty, and all other bits are 0. Read data appears on `bus_rdata` in the cycle after the strobe and holds until the next read.
- R4: A read strobe to address 1 pops the oldest received byte and returns it zero-extended to 32 bits. Status flags change one cycle after the strobe that consumes them, so a status read on the very next cycle already shows the new value.
- R5: A low pulse on the serial input that is shorter than half a bit is not taken as a start bit. A frame whose stop bit is low is discarded. Neither case stops later frames from being received correctly.
- R6: The receive queue holds 20 bytes. A byte that completes while the queue is full is discarded without disturbing the stored bytes, and the receiver continues to accept later frames.
- R7: `rts_n` is driven high when the receive queue holds 16 or more bytes and driven low otherwise. It follows the fill level with one cycle of delay.
- R8: While the synchronized `cts_n` is high, no new frame begins. A frame that has already started when `cts_n` rises is completed.
- R9: After a synchronous reset, both queues are empty, `ser_txd` is high, `rts_n` is low, and the status word reads 1.
- R10: Reads of addresses 2 and 3 return 0. Writes to those addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 2 | Register select: 0 = status, 1 = data |
| bus_wdata | input | 32 | Write data; only the low byte is used |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rdata | output | 32 | Registered read data |
| ser_rxd | input | 1 | Asynchronous serial input |
| ser_txd | output | 1 | Serial output, idle high |
| cts_n | input | 1 | Asynchronous clear-to-send, active low |
| rts_n | output | 1 | Request-to-send, active low |

## Verification
Some properties are checked by assertions on every cycle. These cover the `rts_n` threshold, the receive queue never passing its depth, a completed byte leaving a full queue's fill unchanged, the transmitter staying idle while synchronized `cts_n` is high, the line resting high when the transmitter is idle, and the queue reading empty right after its last byte is popped. Other behaviour can only be shown by the bench's scenarios. This includes bit order and bit length on the wire, and the two stop bits, which are exposed by queuing two bytes back to back. It also includes mid-bit sampling, rejection of glitches and bad stop bits, in-order delivery of exactly twenty bytes after an overrun, and completion of a frame that was already under way when `cts_n` rose.

// File: rtl/sport_pkg.sv
`timescale 1ns/1ps
package sport_pkg;
    // ticks per bit and the centre tick inside the start bit
    localparam int OVERSAMPLE = 16;
    localparam int START_MID  = OVERSAMPLE / 2 - 1;
    localparam int STOP_BITS  = 2;
    localparam int BYTE_W     = 8;

    typedef enum logic [1:0] {
        LN_IDLE,
        LN_START,
        LN_DATA,
        LN_STOP
    } line_state_e;
endpackage

// File: rtl/sport_sync.sv
`timescale 1ns/1ps
module sport_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{RESET_VAL}};
        else     chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/sport_fifo.sv
`timescale 1ns/1ps
module sport_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } fifo_regs_t;

    fifo_regs_t r_d, r_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (r_q.cnt == CNT_W'(DEPTH));
    assign empty   = (r_q.cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_comb begin
        r_d = r_q;
        if (do_push) r_d.wp = wrap_inc(r_q.wp);
        if (do_pop)  r_d.rp = wrap_inc(r_q.rp);
        case ({do_push, do_pop})
            2'b10:   r_d.cnt = r_q.cnt + 1'b1;
            2'b01:   r_d.cnt = r_q.cnt - 1'b1;
            default: r_d.cnt = r_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[r_q.wp] <= din;
    end

    assign dout  = mem_q[r_q.rp];
    assign count = r_q.cnt;
endmodule

// File: rtl/sport_tx.sv
`timescale 1ns/1ps
module sport_tx
    import sport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              have_data,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              cts_ok,
    output logic              take,
    output logic              txd,
    output logic              busy
);
    typedef struct packed {
        line_state_e       st;
        logic [3:0]        ph;
        logic [2:0]        idx;
        logic [BYTE_W-1:0] sh;
        logic              txd;
    } tx_regs_t;

    localparam logic [3:0] PH_LAST = 4'(OVERSAMPLE - 1);

    tx_regs_t r_d, r_q;

    always_comb begin
        r_d  = r_q;
        take = 1'b0;
        unique case (r_q.st)
            LN_IDLE: begin
                r_d.txd = 1'b1;
                if (tick && have_data && cts_ok) begin
                    take     = 1'b1;
                    r_d.sh   = byte_in;
                    r_d.st   = LN_START;
                    r_d.txd  = 1'b0;
                    r_d.ph   = '0;
                end
            end
            LN_START: begin
                if (tick) begin
                    if (r_q.ph == PH_LAST) begin
                        r_d.st  = LN_DATA;
                        r_d.txd = r_q.sh[0];
                        r_d.idx = '0;
                        r_d.ph  = '0;
                    end else begin
                        r_d.ph = r_q.ph + 1'b1;
                    end
                end
            end
            LN_DATA: begin
                if (tick) begin
                    if (r_q.ph == PH_LAST) begin
                        r_d.ph = '0;
                        if (r_q.idx == 3'(BYTE_W - 1)) begin
                            r_d.st  = LN_STOP;
                            r_d.txd = 1'b1;
                            r_d.idx = '0;
                        end else begin
                            r_d.sh  = r_q.sh >> 1;
                            r_d.txd = r_q.sh[1];
                            r_d.idx = r_q.idx + 1'b1;
                        end
                    end else begin
                        r_d.ph = r_q.ph + 1'b1;
                    end
                end
            end
            LN_STOP: begin
                if (tick) begin
                    if (r_q.ph == PH_LAST) begin
                        r_d.ph = '0;
                        if (r_q.idx == 3'(STOP_BITS - 1)) r_d.st  = LN_IDLE;
                        else                              r_d.idx = r_q.idx + 1'b1;
                    end else begin
                        r_d.ph = r_q.ph + 1'b1;
                    end
                end
            end
            default: r_d.st = LN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q     <= '0;
            r_q.st  <= LN_IDLE;
            r_q.txd <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign txd  = r_q.txd;
    assign busy = (r_q.st != LN_IDLE);
endmodule

// File: rtl/sport_rx.sv
`timescale 1ns/1ps
module sport_rx
    import sport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              rxd,
    output logic              got_byte,
    output logic [BYTE_W-1:0] byte_out
);
    typedef struct packed {
        line_state_e       st;
        logic [3:0]        ph;
        logic [2:0]        idx;
        logic [BYTE_W-1:0] sh;
    } rx_regs_t;

    localparam logic [3:0] PH_LAST = 4'(OVERSAMPLE - 1);
    localparam logic [3:0] PH_MID  = 4'(START_MID);

    rx_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        got_byte = 1'b0;
        unique case (r_q.st)
            LN_IDLE: begin
                if (tick && !rxd) begin
                    r_d.st = LN_START;
                    r_d.ph = '0;
                end
            end
            LN_START: begin
                if (tick) begin
                    if (r_q.ph == PH_MID) begin
                        // start confirmed only if still low at its centre
                        r_d.st  = rxd ? LN_IDLE : LN_DATA;
                        r_d.ph  = '0;
                        r_d.idx = '0;
                    end else begin
                        r_d.ph = r_q.ph + 1'b1;
                    end
                end
            end
            LN_DATA: begin
                if (tick) begin
                    if (r_q.ph == PH_LAST) begin
                        r_d.ph = '0;
                        r_d.sh = {rxd, r_q.sh[BYTE_W-1:1]};
                        if (r_q.idx == 3'(BYTE_W - 1)) r_d.st  = LN_STOP;
                        else                           r_d.idx = r_q.idx + 1'b1;
                    end else begin
                        r_d.ph = r_q.ph + 1'b1;
                    end
                end
            end
            LN_STOP: begin
                if (tick) begin
                    if (r_q.ph == PH_LAST) begin
                        got_byte = rxd;
                        r_d.st   = LN_IDLE;
                        r_d.ph   = '0;
                    end else begin
                        r_d.ph = r_q.ph + 1'b1;
                    end
                end
            end
            default: r_d.st = LN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q    <= '0;
            r_q.st <= LN_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign byte_out = r_q.sh;
endmodule

// File: rtl/serial_port_flow.sv
`timescale 1ns/1ps
module serial_port_flow
    import sport_pkg::*;
#(
    parameter int CLK_DIV   = 27,
    parameter int TX_DEPTH  = 4,
    parameter int RX_DEPTH  = 20,
    parameter int RTS_SLACK = 4,
    parameter int ADDR_W    = 2,
    parameter int DATA_W    = 32,
    localparam int RTS_HI   = RX_DEPTH - RTS_SLACK,
    localparam int RX_CNT_W = $clog2(RX_DEPTH + 1),
    localparam int TX_CNT_W = $clog2(TX_DEPTH + 1),
    localparam int DIV_W    = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ser_rxd,
    output logic              ser_txd,
    input  logic              cts_n,
    output logic              rts_n
);
    localparam logic [ADDR_W-1:0] ADR_STATUS = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADR_DATA   = ADDR_W'(1);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              rts_n;
        logic [DIV_W-1:0]  div;
    } top_regs_t;

    top_regs_t r_d, r_q;

    logic tick;
    logic rxd_s, cts_n_s;
    logic tx_push, tx_take, tx_full, tx_empty, tx_busy;
    logic [BYTE_W-1:0] tx_head;
    logic [TX_CNT_W-1:0] unused_tx_count;
    logic rx_push, rx_pop, rx_full, rx_empty;
    logic [BYTE_W-1:0] rx_byte, rx_head;
    logic [RX_CNT_W-1:0] rx_count;
    logic unused_wdata;

    assign unused_wdata = ^bus_wdata[DATA_W-1:BYTE_W];

    sport_sync #(.STAGES(3), .RESET_VAL(1'b1)) u_rxd_sync (
        .clk(clk), .rst(rst), .din(ser_rxd), .dout(rxd_s)
    );

    sport_sync #(.STAGES(2), .RESET_VAL(1'b1)) u_cts_sync (
        .clk(clk), .rst(rst), .din(cts_n), .dout(cts_n_s)
    );

    assign tick    = (r_q.div == DIV_W'(CLK_DIV - 1));
    assign tx_push = bus_wr && (bus_addr == ADR_DATA);
    assign rx_pop  = bus_rd && (bus_addr == ADR_DATA);

    sport_fifo #(.WIDTH(BYTE_W), .DEPTH(TX_DEPTH)) u_tx_fifo (
        .clk(clk), .rst(rst),
        .push(tx_push), .din(bus_wdata[BYTE_W-1:0]),
        .pop(tx_take), .dout(tx_head),
        .count(unused_tx_count), .full(tx_full), .empty(tx_empty)
    );

    sport_tx u_tx (
        .clk(clk), .rst(rst), .tick(tick),
        .have_data(!tx_empty), .byte_in(tx_head), .cts_ok(!cts_n_s),
        .take(tx_take), .txd(ser_txd), .busy(tx_busy)
    );

    sport_rx u_rx (
        .clk(clk), .rst(rst), .tick(tick), .rxd(rxd_s),
        .got_byte(rx_push), .byte_out(rx_byte)
    );

    sport_fifo #(.WIDTH(BYTE_W), .DEPTH(RX_DEPTH)) u_rx_fifo (
        .clk(clk), .rst(rst),
        .push(rx_push), .din(rx_byte),
        .pop(rx_pop), .dout(rx_head),
        .count(rx_count), .full(rx_full), .empty(rx_empty)
    );

    always_comb begin
        r_d     = r_q;
        r_d.div = tick ? '0 : r_q.div + 1'b1;
        r_d.rts_n = (rx_count >= RX_CNT_W'(RTS_HI));
        if (bus_rd) begin
            unique case (bus_addr)
                ADR_STATUS: r_d.rdata = {{(DATA_W-2){1'b0}}, !rx_empty, !tx_full};
                ADR_DATA:   r_d.rdata = rx_empty ? '0
                                      : {{(DATA_W-BYTE_W){1'b0}}, rx_head};
                default:    r_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign bus_rdata = r_q.rdata;
    assign rts_n     = r_q.rts_n;
endmodule

// File: rtl/sport_checks.sv
`timescale 1ns/1ps
module sport_checks #(
    parameter int RX_DEPTH = 20,
    parameter int RTS_HI   = 16,
    parameter int CNT_W    = 5
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] rx_count,
    input logic             rx_push,
    input logic             rx_pop,
    input logic             rx_full,
    input logic             rx_empty,
    input logic             tx_busy,
    input logic             cts_n_s,
    input logic             txd,
    input logic             rts_n
);
    // R7: handshake output follows the fill level one cycle later
    a_r7_rts_high: assert property (@(posedge clk) disable iff (rst)
        (rx_count >= CNT_W'(RTS_HI)) |=> rts_n);
    a_r7_rts_low: assert property (@(posedge clk) disable iff (rst)
        (rx_count < CNT_W'(RTS_HI)) |=> !rts_n);

    // R6: fill never exceeds depth; a byte arriving when full changes nothing
    a_r6_bound: assert property (@(posedge clk) disable iff (rst)
        rx_count <= CNT_W'(RX_DEPTH));
    a_r6_drop_full: assert property (@(posedge clk) disable iff (rst)
        (rx_push && rx_full && !rx_pop) |=> $stable(rx_count));

    // R8: no new frame while clear-to-send is held off
    a_r8_cts_hold: assert property (@(posedge clk) disable iff (rst)
        (!tx_busy && cts_n_s) |=> !tx_busy);

    // R1: line rests high between frames
    a_r1_idle_high: assert property (@(posedge clk) disable iff (rst)
        !tx_busy |-> txd);

    // R4: popping the last byte empties the queue on the next cycle
    a_r4_last_pop: assert property (@(posedge clk) disable iff (rst)
        (rx_pop && rx_count == CNT_W'(1) && !rx_push) |=> rx_empty);
endmodule

bind serial_port_flow sport_checks #(
    .RX_DEPTH(RX_DEPTH), .RTS_HI(RTS_HI), .CNT_W(RX_CNT_W)
) u_sport_checks (
    .clk(clk), .rst(rst), .rx_count(rx_count), .rx_push(rx_push),
    .rx_pop(rx_pop), .rx_full(rx_full), .rx_empty(rx_empty),
    .tx_busy(tx_busy), .cts_n_s(cts_n_s), .txd(ser_txd), .rts_n(rts_n)
);

// File: tb/serial_port_flow_bench.sv
`timescale 1ns/1ps
module serial_port_flow_bench;
    localparam int CLK_DIV = 2;
    localparam int BITC    = 16 * CLK_DIV;
    localparam int NVEC    = 6;
    localparam logic [7:0] VEC [NVEC] = '{8'h55, 8'hA3, 8'h00, 8'hFF, 8'h81, 8'h3C};

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_rd, bus_wr;
    logic [31:0] bus_rdata;
    logic        ser_rxd, ser_txd, cts_n, rts_n;

    int n_checks = 0;
    int n_err    = 0;

    always #2.5 clk = ~clk;

    serial_port_flow #(.CLK_DIV(CLK_DIV)) u_serial_port_flow (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
        .ser_rxd(ser_rxd), .ser_txd(ser_txd), .cts_n(cts_n), .rts_n(rts_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
    endtask

    task automatic send_rx(input logic [7:0] b, input bit good_stop);
        @(negedge clk); ser_rxd = 1'b0;
        repeat (BITC) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            ser_rxd = b[i];
            repeat (BITC) @(negedge clk);
        end
        if (good_stop) begin
            ser_rxd = 1'b1;
        end else begin
            ser_rxd = 1'b0;
            repeat (BITC / 2 + 4) @(negedge clk);
            ser_rxd = 1'b1;
        end
        repeat (BITC) @(negedge clk);
    endtask

    task automatic capture(output logic [7:0] b, output logic ok, input bit drop_cts);
        int guard = 0;
        ok = 1'b1;
        b  = '0;
        while (ser_txd !== 1'b0 && guard < 20 * BITC) begin
            @(negedge clk); guard++;
        end
        if (guard >= 20 * BITC) begin
            ok = 1'b0;
        end else begin
            if (drop_cts) cts_n = 1'b1;
            repeat (BITC / 2) @(negedge clk);
            if (ser_txd !== 1'b0) ok = 1'b0;
            for (int i = 0; i < 8; i++) begin
                repeat (BITC) @(negedge clk);
                b[i] = ser_txd;
            end
            repeat (BITC) @(negedge clk);
            if (ser_txd !== 1'b1) ok = 1'b0;
            repeat (BITC) @(negedge clk);
            if (ser_txd !== 1'b1) ok = 1'b0;
        end
    endtask

    task automatic idle_watch(input int n, output logic seen_low);
        seen_low = 1'b0;
        repeat (n) begin
            @(negedge clk);
            if (ser_txd === 1'b0) seen_low = 1'b1;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  b;
        logic        ok, low;
        rst = 1'b1; bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        ser_rxd = 1'b1; cts_n = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9 reset state
        check("R9 txd idle", {31'b0, ser_txd}, 32'h1);
        check("R9 rts low", {31'b0, rts_n}, 32'h0);
        bus_read(2'd0, v);
        check("R9 status", v, 32'h1);

        // table walk: transmit then receive each vector
        for (int i = 0; i < NVEC; i++) begin
            bus_write(2'd1, {24'hABCDEF, VEC[i]});
            capture(b, ok, 1'b0);
            check("R1 frame shape", {31'b0, ok}, 32'h1);
            check("R2 tx byte", {24'b0, b}, {24'b0, VEC[i]});
            send_rx(VEC[i], 1'b1);
            bus_read(2'd0, v);
            check("R3 status both", v, 32'h3);
            bus_read(2'd1, v);
            check("R4 rx byte", v, {24'b0, VEC[i]});
        end

        // R1 back-to-back frames expose the second stop bit
        bus_write(2'd1, 32'hC5);
        bus_write(2'd1, 32'h3A);
        capture(b, ok, 1'b0);
        check("R1 first ok", {31'b0, ok}, 32'h1);
        check("R1 first byte", {24'b0, b}, 32'hC5);
        capture(b, ok, 1'b0);
        check("R1 second ok", {31'b0, ok}, 32'h1);
        check("R2 order", {24'b0, b}, 32'h3A);

        // R4 flag drops one cycle after pop
        send_rx(8'h66, 1'b1);
        @(negedge clk); bus_rd = 1'b1; bus_addr = 2'd1;
        @(negedge clk); v = bus_rdata; bus_addr = 2'd0;
        check("R4 popped", v, 32'h66);
        @(negedge clk); bus_rd = 1'b0; v = bus_rdata;
        check("R4 flag next cycle", v, 32'h1);

        // R5 glitch and bad stop
        @(negedge clk); ser_rxd = 1'b0;
        repeat (4) @(negedge clk);
        ser_rxd = 1'b1;
        repeat (3 * BITC) @(negedge clk);
        bus_read(2'd0, v);
        check("R5 glitch ignored", v, 32'h1);
        send_rx(8'h5A, 1'b0);
        repeat (2 * BITC) @(negedge clk);
        bus_read(2'd0, v);
        check("R5 bad stop dropped", v, 32'h1);
        send_rx(8'h96, 1'b1);
        bus_read(2'd1, v);
        check("R5 recovers", v, 32'h96);

        // R10 unmapped addresses
        bus_write(2'd2, 32'h77);
        bus_write(2'd3, 32'h11);
        bus_read(2'd2, v);
        check("R10 read addr2", v, 32'h0);
        bus_read(2'd3, v);
        check("R10 read addr3", v, 32'h0);
        idle_watch(12 * BITC, low);
        check("R10 no tx", {31'b0, low}, 32'h0);
        bus_read(2'd0, v);
        check("R10 status", v, 32'h1);

        // R8 hold off, R2 full queue drop
        cts_n = 1'b1;
        repeat (5) @(negedge clk);
        bus_write(2'd1, 32'h11);
        bus_write(2'd1, 32'h22);
        bus_write(2'd1, 32'h33);
        bus_read(2'd0, v);
        check("R3 tx not full", v, 32'h1);
        @(negedge clk); bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 32'h44;
        @(negedge clk); bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = 2'd0;
        @(negedge clk); bus_rd = 1'b0; v = bus_rdata;
        check("R4 tx full flag next cycle", v, 32'h0);
        bus_write(2'd1, 32'hEE);
        idle_watch(12 * BITC, low);
        check("R8 held off", {31'b0, low}, 32'h0);
        cts_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            capture(b, ok, 1'b0);
            check("R2 queued frame ok", {31'b0, ok}, 32'h1);
            check("R2 queued byte", {24'b0, b}, 32'h11 * (i + 1));
        end
        idle_watch(14 * BITC, low);
        check("R2 overflow dropped", {31'b0, low}, 32'h0);

        // R8 frame in progress completes
        bus_write(2'd1, 32'hA5);
        capture(b, ok, 1'b1);
        check("R8 in-flight ok", {31'b0, ok}, 32'h1);
        check("R8 in-flight byte", {24'b0, b}, 32'hA5);
        bus_write(2'd1, 32'h5C);
        idle_watch(12 * BITC, low);
        check("R8 next held", {31'b0, low}, 32'h0);
        cts_n = 1'b0;
        capture(b, ok, 1'b0);
        check("R8 released", {24'b0, b}, 32'h5C);

        // R6 / R7 overrun and threshold
        for (int i = 0; i < 21; i++) begin
            send_rx(8'h10 + 8'(i), 1'b1);
            if (i == 14) check("R7 rts low at 15", {31'b0, rts_n}, 32'h0);
            if (i == 15) check("R7 rts high at 16", {31'b0, rts_n}, 32'h1);
        end
        for (int j = 0; j < 20; j++) begin
            bus_read(2'd1, v);
            check("R6 stored byte", v, 32'h10 + j);
            if (j == 3) begin
                @(negedge clk);
                check("R7 rts high at 16 left", {31'b0, rts_n}, 32'h1);
            end
            if (j == 4) begin
                @(negedge clk);
                check("R7 rts low at 15 left", {31'b0, rts_n}, 32'h0);
            end
        end
        bus_read(2'd0, v);
        check("R6 extra dropped", v, 32'h1);
        send_rx(8'h7E, 1'b1);
        bus_read(2'd1, v);
        check("R6 receiver continues", v, 32'h7E);

        finish_run();
    end
endmodule